// File: doc/BRIEF.md
# Wake-Up and Watchdog Reset Supervisor

This block keeps a sleeping microcontroller alive and sane. It drives a free-running wake-up square wave that interrupts the controller out of sleep, and in return it expects the controller to pull its watchdog line low at least once per wake-up cycle. The first falling edge on the watchdog line cuts the current high phase short. A cycle that passes with no edge ends in a reset pulse.

The same active-low reset output is held low while the supply-good input is false. After the supply comes back, it stays low for a further reset interval. The wake-up output stays low throughout every reset and for a gap after it. Cycling then restarts from the beginning of a cycle.

One parameter, `TICK_BASE`, sets all timing as a count of clock cycles. The wake-up period is 8 bases, the reset interval is 1 base, and the gap from reset release to the first wake-up rise is 4 bases. Both asynchronous inputs are synchronized inside the block. All pins are plain control levels, with no streaming interface.

Top module: `wake_supervisor`

## Requirements
- R1: With B = `TICK_BASE`, the wake-up cycle lasts 8·B clocks, a watchdog-timeout reset lasts B clocks, and the gap from reset release to the first wake-up rise lasts 4·B clocks.
- R2: In a cycle where no watchdog edge cuts it short, `wake_up` rises at the cycle start, stays high for 4·B clocks, and then stays low for 4·B clocks.
- R3: A `wdi` high-to-low transition during the high phase drives `wake_up` low exactly 3 clock edges after the transition. `wake_up` then stays low until the next cycle starts.
- R4: Only the first `wdi` falling edge in a cycle has any effect. Later edges in the same cycle change neither output.
- R5: If no `wdi` falling edge is registered in a whole cycle, `reset_n` goes low on the edge that would have started the next cycle. A falling edge registered in the last clock of the cycle still counts.
- R6: While `power_good` is low, `reset_n` is low; it goes low 3 edges after `power_good` falls. When `power_good` rises, `reset_n` goes high B+2 edges later.
- R7: `wake_up` is low whenever `reset_n` is low, whatever caused the reset.
- R8: After `reset_n` rises, `wake_up` stays low for 4·B clocks and then rises to start a fresh cycle.
- R9: With `wake_up` fed straight back into `wdi`, no watchdog reset ever occurs, and the wave keeps a period of 8·B clocks.
- R10: If `power_good` drops during a watchdog-timeout reset, the reset lasts until `power_good` returns, plus B+2 edges.
- R11: `wdi` edges are ignored while `reset_n` is low, and the edge flag starts clear in every cycle. An edge that arrives during the low phase still satisfies the watchdog.
- R12: While `rst` is asserted, `reset_n` and `wake_up` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high system reset |
| power_good | input | 1 | Supply-good level, asynchronous |
| wdi | input | 1 | Watchdog input from the controller, asynchronous, falling edge active |
| wake_up | output | 1 | Wake-up square wave |
| reset_n | output | 1 | Active-low reset to the controller |

## Verification
Each result has a fixed due time, counted in clock edges from its cause:
- A `wdi` fall reaches `wake_up` after 3 edges.
- A `power_good` fall reaches `reset_n` after 3 edges, and a `power_good` rise after B+2 edges.
- The high phase, the low phase and the reset-to-wake gap each last 4·B edges.
- The timeout reset lands 8·B edges after the cycle start and lasts B edges.

The bench drives inputs on the falling clock edge and counts whole clock periods until the observed output changes. It then compares that count with the figure computed from B, so an early or a late response fails alike. The random watchdog positions keep track of the clocks elapsed in the cycle, so that the next rise is checked at exactly 8·B.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_RST  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } sup_state_e;

  localparam int unsigned CYC_MULT = 8;
  localparam int unsigned RST_MULT = 1;
  localparam int unsigned GAP_MULT = 4;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or posedge rst)
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or posedge rst)
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/sup_fall.sv
module sup_fall (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk or posedge rst)
    if (rst) level_q <= 1'b1;
    else     level_q <= level;

  assign fall = level_q & ~level;
endmodule

// File: rtl/sup_seq.sv
module sup_seq
  import sup_pkg::*;
#(
  parameter int unsigned TICK_BASE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pg_ok,
  input  logic fall,
  output logic wake_up,
  output logic reset_n
);
  localparam int unsigned CYC_LEN = CYC_MULT * TICK_BASE;
  localparam int unsigned RST_LEN = RST_MULT * TICK_BASE;
  localparam int unsigned GAP_LEN = GAP_MULT * TICK_BASE;
  localparam int unsigned CW      = $clog2(CYC_LEN);

  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t CYC_LAST = cnt_t'(CYC_LEN - 1);
  localparam cnt_t RST_LAST = cnt_t'(RST_LEN - 1);
  localparam cnt_t GAP_LAST = cnt_t'(GAP_LEN - 1);
  localparam cnt_t HALF     = cnt_t'(CYC_LEN / 2);

  sup_state_e state;
  cnt_t       cnt;
  logic       seen;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_RST;
      cnt   <= '0;
      seen  <= 1'b0;
    end else if (!pg_ok) begin
      state <= ST_RST;
      cnt   <= '0;
      seen  <= 1'b0;
    end else begin
      case (state)
        ST_RST: begin
          seen <= 1'b0;
          if (cnt == RST_LAST) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          seen <= 1'b0;
          if (cnt == GAP_LAST) begin
            state <= ST_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt == CYC_LAST) begin
            cnt  <= '0;
            seen <= 1'b0;
            if (!(seen || fall)) state <= ST_RST;
          end else begin
            cnt <= cnt + 1'b1;
            if (fall) seen <= 1'b1;
          end
        end
        default: begin
          state <= ST_RST;
          cnt   <= '0;
          seen  <= 1'b0;
        end
      endcase
    end
  end

  assign reset_n = (state != ST_RST);
  assign wake_up = (state == ST_RUN) && (cnt < HALF) && !seen;

  AST_PG_FORCES_RESET: assert property (@(posedge clk) disable iff (rst)
    !pg_ok |=> !reset_n); // R6
  AST_WAKE_LOW_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !reset_n |-> !wake_up); // R7
  AST_EDGE_CUTS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (fall && state == ST_RUN && cnt < HALF - 1'b1) |=> !wake_up); // R3
  AST_SEEN_NO_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && seen && pg_ok) |=> reset_n); // R5
  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && seen && pg_ok && cnt != CYC_LAST) |=> seen); // R4
endmodule

// File: rtl/wake_supervisor.sv
module wake_supervisor #(
  parameter int unsigned TICK_BASE   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic power_good,
  input  logic wdi,
  output logic wake_up,
  output logic reset_n
);
  logic pg_ok;
  logic wdi_s;
  logic wdi_fall;

  sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .rst(rst), .d_in(power_good), .q_out(pg_ok)
  );

  sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wdi_sync (
    .clk(clk), .rst(rst), .d_in(wdi), .q_out(wdi_s)
  );

  sup_fall u_fall (
    .clk(clk), .rst(rst), .level(wdi_s), .fall(wdi_fall)
  );

  sup_seq #(.TICK_BASE(TICK_BASE)) u_seq (
    .clk(clk), .rst(rst), .pg_ok(pg_ok), .fall(wdi_fall),
    .wake_up(wake_up), .reset_n(reset_n)
  );
endmodule

// File: tb/sim_wake_supervisor.sv
module sim_wake_supervisor;
  localparam int B    = 4;
  localparam int CYC  = 8 * B;
  localparam int HALF = 4 * B;
  localparam int GAP  = 4 * B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic power_good = 1'b0;
  logic wdi_drv = 1'b1;
  logic tie = 1'b0;
  logic wdi_in;
  logic wake_up, reset_n;
  int   n_tests = 0;
  int   n_fail  = 0;

  assign wdi_in = tie ? wake_up : wdi_drv;

  always #10 clk = ~clk;

  wake_supervisor #(.TICK_BASE(B)) u0 (
    .clk(clk), .rst(rst), .power_good(power_good), .wdi(wdi_in),
    .wake_up(wake_up), .reset_n(reset_n)
  );

  function automatic int exp_rest(input int elapsed);
    return CYC - elapsed;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // which: 0 = reset_n, 1 = wake_up; counts edges until it equals val
  task automatic wait_sig(input int which, input logic val, output int n);
    n = 0;
    while (((which == 0) ? reset_n : wake_up) !== val && n < 2000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    int el;
    int k;
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    chk("R12 reset_n under rst", int'(reset_n), 0);
    chk("R12 wake_up under rst", int'(wake_up), 0);
    rst = 1'b0;
    tick(20);
    chk("R6 held low without power_good", int'(reset_n), 0);
    chk("R7 wake low during reset", int'(wake_up), 0);

    power_good = 1'b1;
    wait_sig(0, 1'b1, n);
    chk("R6 release delay", n, B + 2);
    wait_sig(1, 1'b1, n);
    chk("R8 gap before first wake", n, GAP);
    wait_sig(1, 1'b0, n);
    chk("R2 high phase length", n, HALF);
    wait_sig(0, 1'b0, n);
    chk("R5 timeout at cycle end", n, CYC - HALF);
    chk("R7 wake low in timeout reset", int'(wake_up), 0);
    wait_sig(0, 1'b1, n);
    chk("R1 reset pulse length", n, B);
    wait_sig(1, 1'b1, n);
    chk("R1 gap length", n, GAP);

    // R9: wake_up tied back to wdi
    tie = 1'b1;
    for (int c = 0; c < 3; c++) begin
      wait_sig(1, 1'b0, n);
      chk("R9 tied high phase", n, HALF);
      wait_sig(1, 1'b1, n);
      chk("R9 tied period", n + HALF, CYC);
      chk("R9 no reset when tied", int'(reset_n), 1);
    end
    tie = 1'b0;

    // R3/R4: random first edge, optional second edge
    for (int it = 0; it < 12; it++) begin
      k = 1 + int'($urandom % 10);
      tick(k);
      wdi_drv = 1'b0;
      wait_sig(1, 1'b0, n);
      chk("R3 edge to wake low", n, 3);
      el = k + n;
      tick(1); wdi_drv = 1'b1; tick(2); el += 3;
      if ($urandom % 2 == 1) begin
        wdi_drv = 1'b0; tick(2); wdi_drv = 1'b1; el += 2;
      end
      wait_sig(1, 1'b1, n);
      chk("R4 wake low until next cycle", n, exp_rest(el));
      chk("R4 no reset after edge", int'(reset_n), 1);
    end

    // R11: edge only in the low phase satisfies the watchdog
    tick(HALF + 2);
    wdi_drv = 1'b0; tick(3); wdi_drv = 1'b1;
    wait_sig(1, 1'b1, n);
    chk("R11 low-phase edge accepted", n, exp_rest(HALF + 5));
    chk("R11 no reset", int'(reset_n), 1);

    // R5 boundary: edge registered in the last clock of the cycle
    tick(CYC - 3);
    wdi_drv = 1'b0;
    wait_sig(1, 1'b1, n);
    chk("R5 last-clock edge counts", n, 3);
    chk("R5 no reset on last-clock edge", int'(reset_n), 1);
    tick(3); wdi_drv = 1'b1;
    wait_sig(1, 1'b0, n);
    wait_sig(1, 1'b1, n);

    // R5 one clock late: cycle missed
    tick(CYC - 2);
    wdi_drv = 1'b0;
    wait_sig(0, 1'b0, n);
    chk("R5 late edge misses cycle", n, 2);
    // R11: edge during reset ignored, first cycle after must time out
    tick(1); wdi_drv = 1'b1; tick(1); wdi_drv = 1'b0; tick(1); wdi_drv = 1'b1;
    wait_sig(0, 1'b1, n);
    wait_sig(1, 1'b1, n);
    chk("R8 gap after timeout reset", n, GAP);
    wait_sig(0, 1'b0, n);
    chk("R11 edge in reset ignored", n, CYC);

    // R10: power_good drop during timeout reset
    tick(1);
    power_good = 1'b0;
    tick(12);
    chk("R10 reset extended", int'(reset_n), 0);
    power_good = 1'b1;
    wait_sig(0, 1'b1, n);
    chk("R10 release after power returns", n, B + 2);
    wait_sig(1, 1'b1, n);

    // R6: power_good drop during run
    tick(5);
    power_good = 1'b0;
    wait_sig(0, 1'b0, n);
    chk("R6 power drop latency", n, 3);
    chk("R7 wake low on power drop", int'(wake_up), 0);

    summary();
  end
endmodule